// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital front end of a serial successive-approximation converter. It runs on a system clock and detects the edges of a slower serial clock line. While the active-low chip select is held low, it accepts an 8-bit control word, one bit per serial-clock rising edge, on the data input. From the number of bits received it opens and closes the track/hold switch and decodes the analog multiplexer selects. It then runs a successive-approximation search with one trial bit per serial-clock cycle, using an external comparator. Finally it shifts the 10-bit result out serially.

The control word is sent most significant bit first. Its first bit is a start bit, which must be 1. Next come a 3-bit channel field, C2 first. Then comes a mode flag (1 = single-ended, 0 = differential), then a coding flag (1 = unipolar, 0 = bipolar), and finally two bits that are ignored. In single-ended mode the positive multiplexer input is the addressed channel and the negative side is the common return. In differential mode the channel field picks one adjacent pair (0/1, 2/3, 4/5, 6/7): the addressed channel is the positive input and its pair partner is the negative input.

Top module: `ser_adc_seq`

## Requirements
- R1: While waiting for a start bit, rising serial-clock edges that sample a 0 on the data input are ignored. Track and hold stay low, and a later 1 begins the control word.
- R2: Track goes high on the serial-clock falling edge after the fifth control bit (the mode flag) and is low before it.
- R3: On the falling edge after the eighth control bit, track goes low and hold goes high in the same clock cycle. Track and hold are never both high.
- R4: Control word layout, MSB first: start(1), C2, C1, C0, mode, coding, two ignored bits. Single-ended mode (mode=1) sets the positive select to the channel field, the common-return flag to 1 and the negative select to 0, all when track goes high.
- R5: Differential mode (mode=0) sets the positive select to the channel field, the negative select to the channel field with its LSB inverted, and the common-return flag to 0.
- R6: When hold begins, the DAC code is 1000000000. Each following rising edge decides one bit, MSB to LSB, keeping it when the comparator input is 1 (DAC below input). The final code is the largest code below the input, or 0.
- R7: The tenth decision drops hold, and the result strobe pulses high for exactly one clock in that same cycle.
- R8: The result appears on the serial output MSB first, one bit per falling edge, starting at the falling edge that follows the tenth decision. The output returns low on the eleventh such falling edge.
- R9: With coding=1 the serial result equals the final DAC code. With coding=0 its MSB is inverted (two's complement).
- R10: Chip select high aborts at once. On the next clock, track, hold, strobe and the serial output are low, and the block waits for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; high aborts |
| sclk | input | 1 | Serial clock, synchronous to clk |
| din | input | 1 | Serial control data |
| cmpIn | input | 1 | Comparator: 1 when DAC is below the input |
| trackEn | output | 1 | Track/hold switch in track |
| holdEn | output | 1 | Hold; sampling node on negative input |
| posSel | output | 3 | Positive multiplexer channel |
| negSel | output | 3 | Negative multiplexer channel (differential) |
| negCom | output | 1 | Negative input is the common return |
| dacCode | output | 10 | SAR DAC trial code |
| dout | output | 1 | Serial result output |
| resultStrobe | output | 1 | One-clock pulse when the result is ready |

## Verification
Chip select going high can fall in the same clock cycle as the serial-clock rising edge that makes the tenth decision. In that cycle, abort and end of conversion compete for the strobe and hold registers. The bench raises chip select and the serial clock on the same system-clock edge. It then expects no strobe pulse, hold low and the serial output low. Abort is also applied in the middle of output shifting on an all-ones result, and the bench checks that the serial output drops to 0.

// File: rtl/ser_adc_pkg.sv
package ser_adc_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RECV = 2'd1,
    ST_CONV = 2'd2,
    ST_OUT  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic shiftCfg;
    logic latchSel;
    logic sarInit;
    logic sarStep;
    logic loadOut;
    logic shiftOut;
    logic doutClr;
  } seqStrobes_t;
endpackage

// File: rtl/ser_adc_ctrl.sv
module ser_adc_ctrl
  import ser_adc_pkg::*;
#(
  parameter int CTRL_BITS = 8,
  parameter int RES_BITS  = 10,
  parameter int CH_BITS   = 3,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             din,
  output seqStrobes_t      stb,
  output logic [CNT_W-1:0] bitIdx,
  output logic             trackEn,
  output logic             holdEn,
  output logic             resultStrobe
);
  localparam int TRACK_AT = CH_BITS + 2;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             sclkQ;
  logic             rise, fall;

  assign rise   = sclk & ~sclkQ;
  assign fall   = ~sclk & sclkQ;
  assign bitIdx = cnt;

  always_comb begin
    stb          = '0;
    stb.clr      = csN;
    stb.shiftCfg = !csN && rise && ((state == ST_WAIT && din) || state == ST_RECV);
    stb.latchSel = !csN && state == ST_RECV && fall && cnt == CNT_W'(TRACK_AT);
    stb.sarInit  = !csN && state == ST_RECV && fall && cnt == CNT_W'(CTRL_BITS);
    stb.sarStep  = !csN && state == ST_CONV && rise;
    stb.loadOut  = !csN && state == ST_CONV && rise && cnt == '0;
    stb.shiftOut = !csN && state == ST_OUT && fall && cnt != '0;
    stb.doutClr  = !csN && state == ST_OUT && fall && cnt == '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ        <= 1'b0;
      state        <= ST_WAIT;
      cnt          <= '0;
      trackEn      <= 1'b0;
      holdEn       <= 1'b0;
      resultStrobe <= 1'b0;
    end else begin
      sclkQ        <= sclk;
      resultStrobe <= 1'b0;
      if (csN) begin
        state   <= ST_WAIT;
        cnt     <= '0;
        trackEn <= 1'b0;
        holdEn  <= 1'b0;
      end else begin
        case (state)
          ST_WAIT: if (rise && din) begin
            state <= ST_RECV;
            cnt   <= CNT_W'(1);
          end
          ST_RECV: begin
            if (rise) cnt <= cnt + 1'b1;
            else if (fall && cnt == CNT_W'(TRACK_AT)) trackEn <= 1'b1;
            else if (fall && cnt == CNT_W'(CTRL_BITS)) begin
              trackEn <= 1'b0;
              holdEn  <= 1'b1;
              state   <= ST_CONV;
              cnt     <= CNT_W'(RES_BITS - 1);
            end
          end
          ST_CONV: if (rise) begin
            if (cnt == '0) begin
              holdEn       <= 1'b0;
              resultStrobe <= 1'b1;
              state        <= ST_OUT;
              cnt          <= CNT_W'(RES_BITS);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_OUT: if (fall) begin
            if (cnt == '0) state <= ST_WAIT;
            else cnt <= cnt - 1'b1;
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser_adc_dp.sv
module ser_adc_dp
  import ser_adc_pkg::*;
#(
  parameter int CTRL_BITS = 8,
  parameter int RES_BITS  = 10,
  parameter int CH_BITS   = 3,
  parameter int CNT_W     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         stb,
  input  logic [CNT_W-1:0]    bitIdx,
  input  logic                din,
  input  logic                cmpIn,
  output logic [CH_BITS-1:0]  posSel,
  output logic [CH_BITS-1:0]  negSel,
  output logic                negCom,
  output logic [RES_BITS-1:0] dacCode,
  output logic                dout
);
  localparam int CFG_W    = CH_BITS + 1;
  localparam int UNI_POS  = CTRL_BITS - (CH_BITS + 3);
  localparam logic [RES_BITS-1:0] MSB_MASK = RES_BITS'(1) << (RES_BITS - 1);

  logic [CFG_W-1:0]    word;
  logic                uniFlag;
  logic [RES_BITS-1:0] trialNext;
  logic [RES_BITS-1:0] outReg;

  always_comb begin
    trialNext = dacCode;
    for (int i = 0; i < RES_BITS; i++) begin
      if (CNT_W'(i) == bitIdx && !cmpIn) trialNext[i] = 1'b0;
      if (CNT_W'(i + 1) == bitIdx)       trialNext[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word    <= '0;
      uniFlag <= 1'b0;
      posSel  <= '0;
      negSel  <= '0;
      negCom  <= 1'b0;
      dacCode <= '0;
      outReg  <= '0;
      dout    <= 1'b0;
    end else if (stb.clr) begin
      word    <= '0;
      uniFlag <= 1'b0;
      posSel  <= '0;
      negSel  <= '0;
      negCom  <= 1'b0;
      dacCode <= '0;
      outReg  <= '0;
      dout    <= 1'b0;
    end else begin
      if (stb.shiftCfg) word <= {word[CFG_W-2:0], din};
      if (stb.latchSel) begin
        posSel <= word[CH_BITS:1];
        negCom <= word[0];
        negSel <= word[0] ? '0 : (word[CH_BITS:1] ^ CH_BITS'(1));
      end
      if (stb.sarInit) begin
        uniFlag <= word[UNI_POS];
        dacCode <= MSB_MASK;
      end
      if (stb.sarStep) dacCode <= trialNext;
      if (stb.loadOut) outReg <= uniFlag ? trialNext : (trialNext ^ MSB_MASK);
      if (stb.shiftOut) begin
        dout   <= outReg[RES_BITS-1];
        outReg <= outReg << 1;
      end
      if (stb.doutClr) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_adc_seq.sv
module ser_adc_seq
  import ser_adc_pkg::*;
#(
  parameter int CTRL_BITS = 8,
  parameter int RES_BITS  = 10,
  parameter int CH_BITS   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                din,
  input  logic                cmpIn,
  output logic                trackEn,
  output logic                holdEn,
  output logic [CH_BITS-1:0]  posSel,
  output logic [CH_BITS-1:0]  negSel,
  output logic                negCom,
  output logic [RES_BITS-1:0] dacCode,
  output logic                dout,
  output logic                resultStrobe
);
  localparam int MAX_CNT = (CTRL_BITS > RES_BITS) ? CTRL_BITS : RES_BITS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  seqStrobes_t      stb;
  logic [CNT_W-1:0] bitIdx;

  ser_adc_ctrl #(.CTRL_BITS(CTRL_BITS), .RES_BITS(RES_BITS), .CH_BITS(CH_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .stb(stb), .bitIdx(bitIdx), .trackEn(trackEn), .holdEn(holdEn),
    .resultStrobe(resultStrobe)
  );

  ser_adc_dp #(.CTRL_BITS(CTRL_BITS), .RES_BITS(RES_BITS), .CH_BITS(CH_BITS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIdx(bitIdx), .din(din), .cmpIn(cmpIn),
    .posSel(posSel), .negSel(negSel), .negCom(negCom), .dacCode(dacCode), .dout(dout)
  );
endmodule

// File: rtl/ser_adc_seq_chk.sv
module ser_adc_seq_chk #(
  parameter int RES_BITS = 10,
  parameter int CH_BITS  = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                trackEn,
  input logic                holdEn,
  input logic [CH_BITS-1:0]  posSel,
  input logic [CH_BITS-1:0]  negSel,
  input logic                negCom,
  input logic [RES_BITS-1:0] dacCode,
  input logic                dout,
  input logic                resultStrobe
);
  localparam logic [RES_BITS-1:0] FIRST_TRIAL = RES_BITS'(1) << (RES_BITS - 1);

  p_track_hold_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(trackEn && holdEn));

  p_hold_from_track_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> $past(trackEn));

  p_first_trial_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> dacCode == FIRST_TRIAL);

  p_pair_select_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((trackEn || holdEn) && !negCom) |->
      (negSel[CH_BITS-1:1] == posSel[CH_BITS-1:1] && negSel[0] != posSel[0]));

  p_strobe_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultStrobe |-> $fell(holdEn));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultStrobe |=> !resultStrobe);

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!trackEn && !holdEn && !dout && !resultStrobe));
endmodule

bind ser_adc_seq ser_adc_seq_chk #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .trackEn(trackEn), .holdEn(holdEn),
  .posSel(posSel), .negSel(negSel), .negCom(negCom), .dacCode(dacCode),
  .dout(dout), .resultStrobe(resultStrobe)
);

// File: tb/sim_ser_adc_seq.sv
module sim_ser_adc_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic cmpIn;
  logic trackEn, holdEn, negCom, dout, resultStrobe;
  logic [2:0] posSel, negSel;
  logic [9:0] dacCode;
  logic [10:0] vinLevel = 11'd0;

  int checks = 0;
  int fails = 0;
  int strobeCnt = 0;
  int wideStrobe = 0;
  bit prevStrobe = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign cmpIn = ({1'b0, dacCode} < vinLevel);

  ser_adc_seq u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .cmpIn(cmpIn),
    .trackEn(trackEn), .holdEn(holdEn), .posSel(posSel), .negSel(negSel),
    .negCom(negCom), .dacCode(dacCode), .dout(dout), .resultStrobe(resultStrobe)
  );

  always @(negedge clk) begin
    if (resultStrobe) strobeCnt++;
    if (resultStrobe && prevStrobe) wideStrobe++;
    prevStrobe = resultStrobe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expCode(input int vin);
    if (vin <= 0) return 0;
    if (vin > 1023) return 1023;
    return vin - 1;
  endfunction

  function automatic int expSerial(input int vin, input bit uni);
    return uni ? expCode(vin) : (expCode(vin) ^ 512);
  endfunction

  task automatic clkBit(input bit b);
    din = b;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic convert(input bit [2:0] ch, input bit sgl, input bit uni,
                         input int vin, input int nz);
    logic [7:0] word;
    logic [9:0] got;
    int s0;
    vinLevel = 11'(vin);
    @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
    for (int z = 0; z < nz; z++) clkBit(1'b0);
    if (nz > 0) chk("R1 idle after leading zeros", int'({trackEn, holdEn}), 0);
    word = {1'b1, ch, sgl, uni, 2'b00};
    for (int i = 7; i >= 0; i--) begin
      clkBit(word[i]);
      if (i == 4) chk("R2 track low before fifth bit", int'(trackEn), 0);
      if (i == 3) begin
        chk("R2 track high after fifth bit", int'(trackEn), 1);
        chk("R4 R5 positive select", int'(posSel), int'(ch));
        chk("R4 R5 common flag", int'(negCom), int'(sgl));
        chk("R4 R5 negative select", int'(negSel), sgl ? 0 : int'(ch ^ 3'd1));
      end
      if (i == 0) begin
        chk("R3 track low at hold", int'(trackEn), 0);
        chk("R3 hold high", int'(holdEn), 1);
        chk("R6 first trial code", int'(dacCode), 512);
      end
    end
    s0 = strobeCnt;
    repeat (9) clkBit(1'b0);
    chk("R7 hold kept before last decision", int'(holdEn), 1);
    chk("R7 no early strobe", strobeCnt, s0);
    clkBit(1'b0);
    chk("R7 hold dropped", int'(holdEn), 0);
    chk("R7 one strobe", strobeCnt, s0 + 1);
    chk("R6 final code", int'(dacCode), expCode(vin));
    got[9] = dout;
    for (int b = 8; b >= 0; b--) begin
      clkBit(1'b0);
      got[b] = dout;
    end
    chk("R8 R9 serial result", int'(got), expSerial(vin, uni));
    clkBit(1'b0);
    chk("R8 output low after result", int'(dout), 0);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", int'({trackEn, holdEn, dout, resultStrobe}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    convert(3'd5, 1'b1, 1'b1, 700, 0);
    convert(3'd2, 1'b0, 1'b1, 301, 3);
    convert(3'd7, 1'b0, 1'b0, 1024, 1);
    convert(3'd0, 1'b1, 1'b0, 0, 2);
    convert(3'd1, 1'b0, 1'b1, 1, 0);
    convert(3'd6, 1'b1, 1'b1, 513, 0);

    begin : rnd
      int seed = $urandom(32'd4242);
      for (int n = 0; n < 20; n++) begin
        convert(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 1024)),
                int'($urandom_range(0, 3)));
      end
      seed = seed;
    end

    begin : abortSameCycle
      int s0;
      vinLevel = 11'd600;
      csN = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 7; i >= 0; i--) clkBit(i == 7 || i == 2);
      repeat (9) clkBit(1'b0);
      s0 = strobeCnt;
      sclk = 1'b1;
      csN = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 abort beats strobe", strobeCnt, s0);
      chk("R10 abort drops hold", int'(holdEn), 0);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end

    begin : abortDuringOutput
      vinLevel = 11'd1024;
      csN = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 7; i >= 0; i--) clkBit(i == 7 || i == 2);
      repeat (13) clkBit(1'b0);
      chk("R8 output high mid result", int'(dout), 1);
      csN = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 abort clears output", int'(dout), 0);
      repeat (2) @(negedge clk);
    end

    convert(3'd3, 1'b0, 1'b0, 257, 1);
    chk("R7 strobe width", wideStrobe, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule